// File: doc/BRIEF.md
# UART Receive-Queue Status and Interrupt Core

This block is the status and interrupt core of one 16550-style UART channel. Received characters arrive on a one-cycle push strobe, each with its data byte and three error flags. They queue in a receive FIFO. The FIFO fill level is compared against a trigger level chosen by software. When the interrupt is enabled, that comparison drives a level-sensitive receive interrupt. Its status bit follows the fill level both upward and downward. No register access is needed to clear it.

A small register port gives access to several functions. Reading the data register pops the oldest character. Software can also set the interrupt enables, program the FIFO control fields and read the line status. The line status register combines four kinds of information: the receive queue state, a sticky overrun flag, the head character's error flags, and a summary of errors across the whole queue. It also carries two transmit-empty flags, which are taken straight from input pins. A separate register holds sticky flow-control detection flags that clear themselves when read.

Reads return data combinationally in the cycle `reg_rd` is high. Their side effects (pop, clear-on-read) take effect at that clock edge.

Register map (`reg_addr`):
- 0: read pops the receive data.
- 1: interrupt enable, bits 3:0.
- 2: read gives the threshold status; write sets FIFO control.
- 5: line status.
- 6: flow-control flags.
- All other addresses read as 0.

Top module: `uart_rx_status`

## Requirements
- R1: After reset the FIFO is empty, the interrupt enable register and the FIFO control fields are 0, `irq` is low, and line status bits 0, 1 and 7 are 0.
- R2: A read of address 0 returns the oldest queued byte and removes it. A read of address 0 with the FIFO empty returns 0 and changes nothing.
- R3: Line status bit 0 is 1 exactly while the FIFO holds at least one character.
- R4: A push while the FIFO already holds DEPTH characters, with no pop in the same cycle, is discarded and sets line status bit 1. That bit stays set until a read of address 5 clears it; a new overrun in the same cycle wins over the clear.
- R5: Line status bits 2, 3 and 4 show the head character's `push_err` bits 0 (parity), 1 (framing) and 2 (break). They are 0 while the FIFO is empty.
- R6: Line status bit 7 is 1 while any character in the FIFO has a nonzero error field.
- R7: Line status bit 5 equals `tx_hold_empty`, and bit 6 equals `tx_hold_empty AND tx_shift_empty`.
- R8: FIFO control write bit 0 enables the FIFO. Bits 7:6 select the trigger level: 00 selects 1, 01 selects DEPTH/4, 10 selects DEPTH/2 and 11 selects DEPTH-2 (1, 4, 8, 14 at depth 16). Bit 0 of a read of address 2 is 1 exactly while the FIFO is enabled and the count is at or above the trigger.
- R9: `irq` equals threshold status AND interrupt enable bit 0. It falls as soon as the count drops below the trigger, with no register read needed.
- R10: With all interrupt enable bits at 0, `irq` stays low while status still updates.
- R11: Address 6 read gives XON-seen in bit 0 and XOFF-seen in bit 1. Each is set by its hit pulse and cleared by the read, and a hit in the same cycle as the read wins.
- R12: A FIFO control write with bit 1 set empties the FIFO, which clears line status bits 0 and 7. It keeps the overrun flag and discards a push in the same cycle without flagging overrun. Bit 1 is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Received character strobe |
| push_data | input | 8 | Received byte |
| push_err | input | 3 | Error flags: bit0 parity, bit1 framing, bit2 break |
| tx_hold_empty | input | 1 | Transmit holding register/FIFO empty |
| tx_shift_empty | input | 1 | Transmit shift register empty |
| xon_hit | input | 1 | XON character detected pulse |
| xoff_hit | input | 1 | XOFF character detected pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| irq | output | 1 | Level receive-data interrupt |

## Verification
The bench builds the block at its default DEPTH of 16. That makes every fill level from empty to full, plus one extra push, cheap to reach for each of the four trigger selections. Interrupt and threshold status are checked at every count, both while filling and while draining. The small depth also lets the bench reach the full-queue overrun discard and a flush from a full queue in a few dozen cycles.

// File: rtl/uart_rxstat_pkg.sv
// Package: shared types, register addresses and trigger-level decode for
// the UART receive status core. Assumes an 8-bit data path.
package uart_rxstat_pkg;

    // Error flags stored with each character; parity in bit 0.
    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } rx_err_t;

    typedef struct packed {
        rx_err_t    err;
        logic [7:0] data;
    } rx_entry_t;

    localparam logic [2:0] ADDR_DATA  = 3'd0;
    localparam logic [2:0] ADDR_IER   = 3'd1;
    localparam logic [2:0] ADDR_CTRL  = 3'd2;
    localparam logic [2:0] ADDR_LSR   = 3'd5;
    localparam logic [2:0] ADDR_XCHAR = 3'd6;

    // Trigger level for a 2-bit select, scaled from the FIFO depth.
    function automatic int unsigned trig_level(input logic [1:0] sel,
                                               input int unsigned depth);
        case (sel)
            2'd0:    return 1;
            2'd1:    return depth / 4;
            2'd2:    return depth / 2;
            default: return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/rxs_fifo.sv
// Receive queue: circular buffer of data+error entries with an occupancy
// count and a count of entries holding any error. Assumes DEPTH >= 4.
// A push when full is accepted only if a pop frees a slot the same cycle;
// flush overrides push and pop.
module rxs_fifo
    import uart_rxstat_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            push,
    input  rx_entry_t       push_entry,
    input  logic            pop,
    output rx_entry_t       head,
    output logic [CW-1:0]   count,
    output logic            full,
    output logic            empty,
    output logic            err_any
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    rx_entry_t       mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic [CW-1:0]   err_cnt;
    logic            do_push, do_pop, push_bad, pop_bad;

    // Qualify the requested push and pop against occupancy and flush.
    always_comb begin
        empty    = (count == '0);
        full     = (count == CW'(DEPTH));
        do_pop   = pop && !empty && !flush;
        do_push  = push && (!full || do_pop) && !flush;
        push_bad = do_push && (push_entry.err != '0);
        pop_bad  = do_pop && (head.err != '0);
        head     = mem[rd_ptr];
        err_any  = (err_cnt != '0);
    end

    // Storage write; contents need no reset because the count guards reads.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_entry;
    end

    // Pointers, occupancy count and errored-entry count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            err_cnt <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            count   <= count + CW'(do_push) - CW'(do_pop);
            err_cnt <= err_cnt + CW'(push_bad) - CW'(pop_bad);
        end
    end

    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    a_r6_err_within_count: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt <= count);
    a_r4_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (count == CW'(DEPTH)));
    a_r12_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0 && !err_any));
    a_r2_empty_pop_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !push) |=> empty);

endmodule

// File: rtl/rxs_flags.sv
// Sticky event flags: receive overrun (cleared by a line-status read) and
// XON/XOFF detection (cleared by a flag-register read). In every flag a
// set in the same cycle as its clear wins, so no event is lost.
module rxs_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic ovr_set,
    input  logic ovr_clr,
    input  logic xon_set,
    input  logic xoff_set,
    input  logic xchar_clr,
    output logic ovr_q,
    output logic xon_q,
    output logic xoff_q
);

    // Hold each flag until its clearing read; a set overrides the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q  <= 1'b0;
            xon_q  <= 1'b0;
            xoff_q <= 1'b0;
        end else begin
            ovr_q  <= ovr_set  || (ovr_q  && !ovr_clr);
            xon_q  <= xon_set  || (xon_q  && !xchar_clr);
            xoff_q <= xoff_set || (xoff_q && !xchar_clr);
        end
    end

    a_r4_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !ovr_clr) |=> ovr_q);
    a_r11_xon_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        xon_set |=> xon_q);
    a_r11_xoff_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (xchar_clr && !xoff_set) |=> !xoff_q);

endmodule

// File: rtl/uart_rx_status.sv
// Top: register port, FIFO control, line-status assembly and the level
// receive interrupt for one UART channel. Reads are combinational;
// pop and clear-on-read side effects apply at the clock edge of reg_rd.
module uart_rx_status
    import uart_rxstat_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_valid,
    input  logic [7:0] push_data,
    input  logic [2:0] push_err,
    input  logic       tx_hold_empty,
    input  logic       tx_shift_empty,
    input  logic       xon_hit,
    input  logic       xoff_hit,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq
);

    logic [3:0]    ier_q;
    logic          fifo_en_q;
    logic [1:0]    trig_sel_q;
    logic [CW-1:0] trig_lvl, count;
    logic          ctrl_wr, flush, pop, lsr_rd, xchar_rd, ovr_set;
    logic          full, empty, err_any, thresh;
    logic          ovr_q, xon_q, xoff_q;
    rx_entry_t     head, in_entry;
    logic [7:0]    lsr;
    logic          unused_wbits;

    // Decode register strobes into block actions.
    always_comb begin
        ctrl_wr  = reg_wr && (reg_addr == ADDR_CTRL);
        flush    = ctrl_wr && reg_wdata[1];
        pop      = reg_rd && (reg_addr == ADDR_DATA);
        lsr_rd   = reg_rd && (reg_addr == ADDR_LSR);
        xchar_rd = reg_rd && (reg_addr == ADDR_XCHAR);
        ovr_set  = push_valid && full && !pop && !flush;
        in_entry = '{err: rx_err_t'(push_err), data: push_data};
        unused_wbits = ^reg_wdata[5:2];
    end

    // Software-visible enable and FIFO control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ier_q      <= '0;
            fifo_en_q  <= 1'b0;
            trig_sel_q <= '0;
        end else begin
            if (reg_wr && reg_addr == ADDR_IER) ier_q <= reg_wdata[3:0];
            if (ctrl_wr) begin
                fifo_en_q  <= reg_wdata[0];
                trig_sel_q <= reg_wdata[7:6];
            end
        end
    end

    rxs_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(push_valid),
        .push_entry(in_entry), .pop(pop), .head(head), .count(count),
        .full(full), .empty(empty), .err_any(err_any)
    );

    rxs_flags u_flags (
        .clk(clk), .rst_n(rst_n), .ovr_set(ovr_set), .ovr_clr(lsr_rd),
        .xon_set(xon_hit), .xoff_set(xoff_hit), .xchar_clr(xchar_rd),
        .ovr_q(ovr_q), .xon_q(xon_q), .xoff_q(xoff_q)
    );

    // Threshold compare, interrupt and line-status assembly.
    always_comb begin
        trig_lvl = CW'(trig_level(trig_sel_q, DEPTH));
        thresh   = fifo_en_q && (count >= trig_lvl);
        irq      = thresh && ier_q[0];
        lsr      = {err_any, tx_hold_empty && tx_shift_empty, tx_hold_empty,
                    empty ? 3'b000 : head.err, ovr_q, !empty};
    end

    // Read-data multiplexer.
    always_comb begin
        case (reg_addr)
            ADDR_DATA:  reg_rdata = empty ? 8'h00 : head.data;
            ADDR_IER:   reg_rdata = {4'b0000, ier_q};
            ADDR_CTRL:  reg_rdata = {7'b0, thresh};
            ADDR_LSR:   reg_rdata = lsr;
            ADDR_XCHAR: reg_rdata = {6'b0, xoff_q, xon_q};
            default:    reg_rdata = 8'h00;
        endcase
    end

    a_r10_polled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_q == 4'b0000) |-> !irq);
    a_r9_irq_falls_below: assert property (@(posedge clk) disable iff (!rst_n)
        (count < trig_lvl) |-> !irq);
    a_r3_ready_tracks_fifo: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr[0] && !pop && !flush) |=> lsr[0]);
    a_r7_tx_empty_order: assert property (@(posedge clk) disable iff (!rst_n)
        lsr[6] |-> lsr[5]);

endmodule

// File: tb/uart_rx_status_bench.sv
`timescale 1ns/1ps
module uart_rx_status_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_valid = 1'b0;
    logic [7:0] push_data = '0;
    logic [2:0] push_err = '0;
    logic       tx_hold_empty = 1'b1, tx_shift_empty = 1'b1;
    logic       xon_hit = 1'b0, xoff_hit = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int nchk = 0, nfail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    uart_rx_status u_uart_rx_status (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid),
        .push_data(push_data), .push_err(push_err),
        .tx_hold_empty(tx_hold_empty), .tx_shift_empty(tx_shift_empty),
        .xon_hit(xon_hit), .xoff_hit(xoff_hit), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic [2:0] e);
        @(negedge clk);
        push_valid = 1'b1; push_data = d; push_err = e;
        @(posedge clk); #1 push_valid = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1 reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(posedge clk); #1 reg_rd = 1'b0;
    endtask

    function automatic int trig_of(input int sel);
        return (sel == 0) ? 1 : (sel == 1) ? 4 : (sel == 2) ? 8 : 14;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++; nchk++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [2:0] errs [5];
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        #1 chk("R1 irq", int'(irq), 0);
        rd(5, v); chk("R1 lsr", int'(v), 8'h60);
        rd(1, v); chk("R1 ier", int'(v), 0);
        rd(2, v); chk("R1 thresh", int'(v), 0);

        // R7 transmit flags, all four input combinations
        for (int c = 0; c < 4; c++) begin
            tx_hold_empty = c[0]; tx_shift_empty = c[1];
            rd(5, v);
            chk("R7 lsr6:5", int'(v[6:5]), (c[0] & c[1]) * 2 + c[0]);
        end
        tx_hold_empty = 1'b1; tx_shift_empty = 1'b1;

        // R8/R9/R2/R3 sweep of every fill level for every trigger select
        for (int sel = 0; sel < 4; sel++) begin
            int t;
            t = trig_of(sel);
            wr(1, 8'h01);
            wr(2, 8'(sel << 6) | 8'h03);
            for (int k = 1; k <= 16; k++) begin
                push(8'(sel * 16 + k), 3'b000);
                chk("R9 irq rising", int'(irq), int'(k >= t));
                rd(2, v); chk("R8 thresh", int'(v), int'(k >= t));
            end
            for (int k = 16; k >= 1; k--) begin
                rd(0, v); chk("R2 order", int'(v), sel * 16 + 17 - k);
                chk("R9 irq falling", int'(irq), int'((k - 1) >= t));
            end
            rd(5, v); chk("R3 empty bit0", int'(v[0]), 0);
        end

        // R10 polled mode: status updates, interrupt stays low
        wr(1, 8'h00);
        wr(2, 8'h43);
        for (int k = 0; k < 5; k++) push(8'(k), 3'b000);
        chk("R10 irq low", int'(irq), 0);
        rd(2, v); chk("R10 thresh", int'(v), 1);
        rd(5, v); chk("R3 ready", int'(v[0]), 1);
        wr(2, 8'h03);

        // R5/R6 per-head errors and queue-wide error summary
        errs[0] = 3'b000; errs[1] = 3'b001; errs[2] = 3'b010;
        errs[3] = 3'b100; errs[4] = 3'b000;
        for (int i = 0; i < 5; i++) push(8'hA0 + 8'(i), errs[i]);
        for (int i = 0; i < 5; i++) begin
            int anyerr;
            anyerr = 0;
            for (int j = i; j < 5; j++) if (errs[j] != 0) anyerr = 1;
            rd(5, v);
            chk("R5 head errors", int'(v[4:2]), int'(errs[i]));
            chk("R6 summary", int'(v[7]), anyerr);
            rd(0, v); chk("R2 data", int'(v), 8'hA0 + i);
        end
        rd(5, v);
        chk("R5 empty errors", int'(v[4:2]), 0);
        chk("R6 empty summary", int'(v[7]), 0);
        rd(0, v); chk("R2 empty read", int'(v), 0);

        // R12 flush keeps overrun, clears bits 0 and 7
        for (int k = 0; k < 16; k++) push(8'(k), (k == 3) ? 3'b010 : 3'b000);
        push(8'hEE, 3'b000);
        wr(2, 8'h03);
        rd(5, v);
        chk("R12 bit0", int'(v[0]), 0);
        chk("R12 bit7", int'(v[7]), 0);
        chk("R12 keeps overrun", int'(v[1]), 1);
        rd(5, v); chk("R4 cleared by read", int'(v[1]), 0);

        // R12 push in flush cycle is discarded, no overrun
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 8'h03;
        push_valid = 1'b1; push_data = 8'h55; push_err = 3'b000;
        @(posedge clk); #1 reg_wr = 1'b0; push_valid = 1'b0;
        rd(5, v);
        chk("R12 same-cycle push", int'(v[1:0]), 0);

        // R4 overrun discards the extra character
        for (int k = 0; k < 16; k++) push(8'(8'h30 + k), 3'b000);
        rd(5, v); chk("R4 no overrun at full", int'(v[1]), 0);
        push(8'hEE, 3'b000);
        rd(5, v); chk("R4 overrun set", int'(v[1]), 1);
        for (int k = 0; k < 16; k++) begin
            rd(0, v); chk("R4 drain", int'(v), 8'h30 + k);
        end
        rd(0, v); chk("R4 extra dropped", int'(v), 0);

        // R11 flow-control flags
        @(negedge clk) xon_hit = 1'b1; @(posedge clk); #1 xon_hit = 1'b0;
        rd(6, v); chk("R11 xon", int'(v), 1);
        rd(6, v); chk("R11 clear", int'(v), 0);
        @(negedge clk) begin xon_hit = 1'b1; xoff_hit = 1'b1; end
        @(posedge clk); #1 begin xon_hit = 1'b0; xoff_hit = 1'b0; end
        rd(6, v); chk("R11 both", int'(v), 3);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 3'd6; xoff_hit = 1'b1;
        #1 chk("R11 read before set", int'(reg_rdata), 0);
        @(posedge clk); #1 begin reg_rd = 1'b0; xoff_hit = 1'b0; end
        rd(6, v); chk("R11 set wins", int'(v), 2);

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule